// File: doc/BRIEF.md
# Frame ring-buffer stream controller

This block sits between a client that produces and consumes data frames and an inference engine that turns one input frame into one output frame. Both kinds of frame live in external memory: input frames in one region and output frames in another. Each region is split into fixed-size slots. The controller decides which slot the client writes or reads next. It tells the engine which input slot to read and which output slot to fill, and it reports when a run is complete.

There are two ways to run it. In batch mode the client has already placed every input frame in consecutive slots. A start pulse makes the controller feed the engine one frame after another, with no handshake at the client side. In streaming mode each region becomes a ring of `ring_depth` slots. The client writes a frame whenever the controller offers a free input slot, and it reads a result whenever the controller offers a finished output slot. A full ring at either side holds the flow back, one slot at a time. A frame count of zero in streaming mode keeps the controller running until the client asserts stop.

Top module: `frs_ring_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `in_valid`, `out_valid`, `done` and `eng_start` are low.
- R2: In batch mode (`stream_mode`=0) with count N≥1, a start pulse makes the engine run N frames, one at a time. Frame k uses input address in_base+k·IN_BYTES and output address out_base+k·OUT_BYTES. `in_valid` and `out_valid` stay low throughout, and `done` rises only after the N-th `eng_done`.
- R3: In batch mode, a start with a frame count of zero launches no frame and never raises `done`.
- R4: In streaming mode (`stream_mode`=1) with count N≥1, the controller accepts exactly N input frames and delivers N output frames. It raises `done` only after the N-th engine completion.
- R5: While `in_valid` is high, `in_addr` equals in_base+w·IN_BYTES and `in_size` equals IN_BYTES. Here w is the number of frames accepted since start, taken modulo `ring_depth`. An `in_next` pulse while `in_valid` is high hands that slot over.
- R6: While `out_valid` is high, `out_addr` equals out_base+r·OUT_BYTES and `out_size` equals OUT_BYTES. Here r is the number of outputs released since start, taken modulo `ring_depth`. An `out_next` pulse while `out_valid` is high releases the slot.
- R7: In streaming mode the engine is started on the oldest filled input slot, and only when an output slot is free. At most one frame is in flight at a time. The k-th launch uses the input slot and the output slot whose index is k modulo `ring_depth`.
- R8: If the client never releases outputs, the controller keeps accepting inputs until the input ring holds `ring_depth` frames. With a depth of 2 this means 4 accepted inputs and 2 engine runs, after which `in_valid` stays low and `out_valid` stays high.
- R9: When `use_user_base`=1 at start, the bases are `user_in_base` and `user_out_base`. Otherwise they are the defaults DEF_IN_BASE=0x1000_0000 and DEF_OUT_BASE=0x2000_0000. The bases are captured at the start pulse.
- R10: In continuous streaming (count 0), stop lets any frame already in flight complete. The controller then goes idle with both valids and `done` low. All slot pointers are reset, so the next start offers slot 0 again.
- R11: `done` stays high until the next start. A start is accepted only when the controller is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_mode | input | 1 | 0 batch, 1 streaming; captured at start |
| frame_count | input | CNT_W | Frames to process; 0 means continuous in streaming mode |
| ring_depth | input | DEP_W | Slots per ring, 2..MAX_DEPTH |
| use_user_base | input | 1 | 1 selects the user bases, 0 the defaults |
| user_in_base | input | 32 | User input region base |
| user_out_base | input | 32 | User output region base |
| start | input | 1 | Start pulse |
| stop | input | 1 | Ends continuous streaming |
| in_valid | output | 1 | A free input slot is offered |
| in_addr | output | 32 | Address of the offered input slot |
| in_size | output | 32 | Input frame size in bytes |
| in_next | input | 1 | Client has written the offered slot |
| out_valid | output | 1 | A finished output slot is offered |
| out_addr | output | 32 | Address of the oldest finished output |
| out_size | output | 32 | Output frame size in bytes |
| out_next | input | 1 | Client has read the offered slot |
| eng_start | output | 1 | One-cycle engine launch |
| eng_in_addr | output | 32 | Input frame address for the engine |
| eng_out_addr | output | 32 | Output frame address for the engine |
| eng_done | input | 1 | Engine finished the frame in flight |
| done | output | 1 | All requested frames processed |

## Verification
The checker assumes the engine pulses `eng_done` only while a frame is in flight, and never in the cycle of its own `eng_start`. It also assumes the client raises `in_next` and `out_next` only while the matching valid is high, and keeps `ring_depth` at 2 or more. The bench meets these assumptions by driving every input at the falling edge from values it sampled at that same edge. Its engine model answers exactly two cycles after each launch, and every depth it uses lies between 2 and 8.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int FRS_AW = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } frs_state_e;

  // byte address of slot idx in a region of equal-size frames
  function automatic logic [FRS_AW-1:0] slot_addr(
    input logic [FRS_AW-1:0] base,
    input logic [FRS_AW-1:0] idx,
    input logic [FRS_AW-1:0] bytes);
    return base + idx * bytes;
  endfunction

  // ring successor: wraps to zero after depth-1
  function automatic logic [FRS_AW-1:0] next_slot(
    input logic [FRS_AW-1:0] idx,
    input logic [FRS_AW-1:0] depth);
    return ((idx + 1) >= depth) ? '0 : idx + 1;
  endfunction
endpackage

// File: rtl/frs_ring.sv
module frs_ring #(
  parameter int IDX_W = 3,
  parameter int DEP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DEP_W-1:0] depth,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [DEP_W-1:0] occ
);
  import frs_pkg::*;

  logic [IDX_W-1:0] wr_nx, rd_nx;

  always_comb begin
    wr_nx = IDX_W'(next_slot(FRS_AW'(wr_idx), FRS_AW'(depth)));
    rd_nx = IDX_W'(next_slot(FRS_AW'(rd_idx), FRS_AW'(depth)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_idx <= '0;
      rd_idx <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_idx <= wr_nx;
      if (pop)  rd_idx <= rd_nx;
      occ <= occ + DEP_W'(push) - DEP_W'(pop);
    end
  end
endmodule

// File: rtl/frs_engine_ctl.sv
module frs_engine_ctl #(
  parameter int CNT_W = 16,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             launch,
  input  logic [AW-1:0]    in_addr_nx,
  input  logic [AW-1:0]    out_addr_nx,
  input  logic             eng_done,
  output logic             eng_start,
  output logic [AW-1:0]    eng_in_addr,
  output logic [AW-1:0]    eng_out_addr,
  output logic             busy,
  output logic             finish,
  output logic [CNT_W-1:0] completed
);
  assign finish = eng_done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_start    <= 1'b0;
      busy         <= 1'b0;
      eng_in_addr  <= '0;
      eng_out_addr <= '0;
      completed    <= '0;
    end else begin
      eng_start <= launch;
      if (launch) begin
        busy         <= 1'b1;
        eng_in_addr  <= in_addr_nx;
        eng_out_addr <= out_addr_nx;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (clr)         completed <= '0;
      else if (finish) completed <= completed + 1'b1;
    end
  end
endmodule

// File: rtl/frs_ring_seq.sv
module frs_ring_seq #(
  parameter int          CNT_W        = 16,
  parameter int          MAX_DEPTH    = 8,
  parameter logic [31:0] IN_BYTES     = 32'h0000_1000,
  parameter logic [31:0] OUT_BYTES    = 32'h0000_0200,
  parameter logic [31:0] DEF_IN_BASE  = 32'h1000_0000,
  parameter logic [31:0] DEF_OUT_BASE = 32'h2000_0000,
  localparam int         DEP_W        = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stream_mode,
  input  logic [CNT_W-1:0] frame_count,
  input  logic [DEP_W-1:0] ring_depth,
  input  logic             use_user_base,
  input  logic [31:0]      user_in_base,
  input  logic [31:0]      user_out_base,
  input  logic             start,
  input  logic             stop,
  output logic             in_valid,
  output logic [31:0]      in_addr,
  output logic [31:0]      in_size,
  input  logic             in_next,
  output logic             out_valid,
  output logic [31:0]      out_addr,
  output logic [31:0]      out_size,
  input  logic             out_next,
  output logic             eng_start,
  output logic [31:0]      eng_in_addr,
  output logic [31:0]      eng_out_addr,
  input  logic             eng_done,
  output logic             done
);
  import frs_pkg::*;

  localparam int IDX_W = $clog2(MAX_DEPTH);
  localparam int AW    = FRS_AW;

  frs_state_e       state_q;
  logic             mode_q;
  logic [CNT_W-1:0] count_q;
  logic [DEP_W-1:0] depth_q;
  logic [AW-1:0]    in_base_q, out_base_q;
  logic [CNT_W-1:0] accepted_q;

  // named internal events
  logic             start_ok, clear_all, launch, continuous;
  logic             in_push, in_pop, out_push, out_pop;
  logic             busy, finish, all_done;
  logic [CNT_W-1:0] completed;
  logic [IDX_W-1:0] in_wr, in_rd, out_wr, out_rd;
  logic [DEP_W-1:0] in_occ, out_occ;
  logic [AW-1:0]    eng_in_nx, eng_out_nx;

  assign continuous = mode_q && (count_q == '0);
  assign start_ok   = start && (state_q == ST_IDLE || state_q == ST_FIN);
  assign clear_all  = start_ok || (state_q == ST_DRAIN && !busy);
  assign all_done   = (count_q != '0) && (completed == count_q);

  // client handshakes
  assign in_valid  = (state_q == ST_RUN) && mode_q && (in_occ < depth_q) &&
                     ((count_q == '0) || (accepted_q < count_q));
  assign out_valid = mode_q && (state_q == ST_RUN || state_q == ST_FIN) &&
                     (out_occ != '0);
  assign in_addr   = slot_addr(in_base_q, AW'(in_wr), IN_BYTES);
  assign out_addr  = slot_addr(out_base_q, AW'(out_rd), OUT_BYTES);
  assign in_size   = IN_BYTES;
  assign out_size  = OUT_BYTES;

  assign in_push  = in_next && in_valid;
  assign out_pop  = out_next && out_valid;
  assign in_pop   = finish && mode_q;
  assign out_push = finish && mode_q;

  // engine scheduling
  always_comb begin
    launch = 1'b0;
    if (state_q == ST_RUN && !busy) begin
      if (mode_q) launch = (in_occ != '0) && (out_occ < depth_q);
      else        launch = (completed < count_q);
    end
    if (mode_q) begin
      eng_in_nx  = slot_addr(in_base_q, AW'(in_rd), IN_BYTES);
      eng_out_nx = slot_addr(out_base_q, AW'(out_wr), OUT_BYTES);
    end else begin
      eng_in_nx  = slot_addr(in_base_q, AW'(completed), IN_BYTES);
      eng_out_nx = slot_addr(out_base_q, AW'(completed), OUT_BYTES);
    end
  end

  frs_ring #(.IDX_W(IDX_W), .DEP_W(DEP_W)) u_in_ring (
    .clk(clk), .rst_n(rst_n), .clr(clear_all), .depth(depth_q),
    .push(in_push), .pop(in_pop),
    .wr_idx(in_wr), .rd_idx(in_rd), .occ(in_occ));

  frs_ring #(.IDX_W(IDX_W), .DEP_W(DEP_W)) u_out_ring (
    .clk(clk), .rst_n(rst_n), .clr(clear_all), .depth(depth_q),
    .push(out_push), .pop(out_pop),
    .wr_idx(out_wr), .rd_idx(out_rd), .occ(out_occ));

  frs_engine_ctl #(.CNT_W(CNT_W), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(clear_all), .launch(launch),
    .in_addr_nx(eng_in_nx), .out_addr_nx(eng_out_nx), .eng_done(eng_done),
    .eng_start(eng_start), .eng_in_addr(eng_in_addr),
    .eng_out_addr(eng_out_addr), .busy(busy), .finish(finish),
    .completed(completed));

  // run control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      count_q    <= '0;
      depth_q    <= DEP_W'(2);
      in_base_q  <= DEF_IN_BASE;
      out_base_q <= DEF_OUT_BASE;
      accepted_q <= '0;
    end else begin
      if (clear_all)    accepted_q <= '0;
      else if (in_push) accepted_q <= accepted_q + 1'b1;
      if (start_ok) begin
        mode_q     <= stream_mode;
        count_q    <= frame_count;
        depth_q    <= ring_depth;
        in_base_q  <= use_user_base ? user_in_base  : DEF_IN_BASE;
        out_base_q <= use_user_base ? user_out_base : DEF_OUT_BASE;
        state_q    <= (!stream_mode && frame_count == '0) ? ST_IDLE : ST_RUN;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (all_done)                state_q <= ST_FIN;
            else if (continuous && stop) state_q <= ST_DRAIN;
          end
          ST_DRAIN: if (!busy) state_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign done = (state_q == ST_FIN);
endmodule

// File: rtl/frs_ring_seq_chk.sv
module frs_ring_seq_chk #(
  parameter int DEP_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input frs_pkg::frs_state_e state_q,
  input logic                mode_q,
  input logic [DEP_W-1:0]    depth_q,
  input logic [DEP_W-1:0]    in_occ,
  input logic [DEP_W-1:0]    out_occ,
  input logic                in_valid,
  input logic                out_valid,
  input logic                eng_start,
  input logic                start,
  input logic                done
);
  import frs_pkg::*;

  AST_BATCH_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (!in_valid && !out_valid));                           // R2
  AST_OUT_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_occ <= depth_q);                                              // R6
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);                                        // R7
  AST_LAUNCH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && mode_q) |-> (out_occ < depth_q));                   // R7
  AST_IN_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_occ <= depth_q);                                               // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!in_valid && !out_valid && !done));     // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                       // R11
endmodule

bind frs_ring_seq frs_ring_seq_chk #(.DEP_W(DEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .mode_q(mode_q),
  .depth_q(depth_q), .in_occ(in_occ), .out_occ(out_occ),
  .in_valid(in_valid), .out_valid(out_valid), .eng_start(eng_start),
  .start(start), .done(done));

// File: tb/tb_frs_ring_seq.sv
module tb_frs_ring_seq;
  localparam logic [31:0] IB  = 32'h0000_1000;
  localparam logic [31:0] OB  = 32'h0000_0200;
  localparam logic [31:0] DIB = 32'h1000_0000;
  localparam logic [31:0] DOB = 32'h2000_0000;
  localparam logic [31:0] UIB = 32'h4000_0000;
  localparam logic [31:0] UOB = 32'h5000_0000;

  typedef struct packed {
    logic        mode;
    logic [15:0] cnt;
    logic [3:0]  dep;
    logic        user;
    logic        gap;
    logic [1:0]  stall;
    logic [15:0] exp_runs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd3, 4'd2, 1'b0, 1'b0, 2'd0, 16'd3},
    '{1'b0, 16'd1, 4'd2, 1'b1, 1'b0, 2'd0, 16'd1},
    '{1'b1, 16'd5, 4'd2, 1'b0, 1'b0, 2'd0, 16'd5},
    '{1'b1, 16'd7, 4'd3, 1'b1, 1'b0, 2'd2, 16'd7},
    '{1'b1, 16'd9, 4'd4, 1'b0, 1'b1, 2'd3, 16'd9},
    '{1'b1, 16'd4, 4'd8, 1'b1, 1'b1, 2'd1, 16'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic stream_mode = 1'b0, use_user_base = 1'b0, start = 1'b0, stop = 1'b0;
  logic [15:0] frame_count = '0;
  logic [3:0]  ring_depth = 4'd2;
  logic in_next = 1'b0, out_next = 1'b0, eng_done = 1'b0;
  logic in_valid, out_valid, eng_start, done;
  logic [31:0] in_addr, in_size, out_addr, out_size, eng_in_addr, eng_out_addr;

  always #4 clk = ~clk;

  frs_ring_seq dut (
    .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode),
    .frame_count(frame_count), .ring_depth(ring_depth),
    .use_user_base(use_user_base), .user_in_base(UIB), .user_out_base(UOB),
    .start(start), .stop(stop), .in_valid(in_valid), .in_addr(in_addr),
    .in_size(in_size), .in_next(in_next), .out_valid(out_valid),
    .out_addr(out_addr), .out_size(out_size), .out_next(out_next),
    .eng_start(eng_start), .eng_in_addr(eng_in_addr),
    .eng_out_addr(eng_out_addr), .eng_done(eng_done), .done(done));

  int checks = 0, errors = 0;
  int wr_n, rd_n, eng_n, fin_n, timer, cyc;
  bit v_mode, saw_hs;
  int v_dep;
  logic [31:0] v_ib, v_ob;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one falling-edge step: sample, then model engine and client
  task automatic step(input bit feed, input bit take);
    logic s_iv, s_ov, s_es;
    logic [31:0] s_ia, s_is, s_oa, s_os, s_ei, s_eo, e;
    @(negedge clk);
    cyc++;
    s_iv = in_valid; s_ov = out_valid; s_es = eng_start;
    s_ia = in_addr; s_is = in_size; s_oa = out_addr; s_os = out_size;
    s_ei = eng_in_addr; s_eo = eng_out_addr;
    eng_done = 1'b0;
    if (timer != 0) begin
      timer--;
      if (timer == 0) begin eng_done = 1'b1; fin_n++; end
    end
    if (s_es) begin
      e = v_mode ? v_ib + IB * 32'(eng_n % v_dep) : v_ib + IB * 32'(eng_n);
      check(s_ei == e, "R7 R2 R9 engine input address", s_ei, e);
      e = v_mode ? v_ob + OB * 32'(eng_n % v_dep) : v_ob + OB * 32'(eng_n);
      check(s_eo == e, "R7 R2 R9 engine output address", s_eo, e);
      eng_n++;
      timer = 2;
    end
    in_next = 1'b0;
    if (s_iv) begin
      saw_hs = 1'b1;
      e = v_ib + IB * 32'(wr_n % v_dep);
      check(s_ia == e && s_is == IB, "R5 input slot", s_ia, e);
      if (feed) begin in_next = 1'b1; wr_n++; end
    end
    out_next = 1'b0;
    if (s_ov) begin
      saw_hs = 1'b1;
      e = v_ob + OB * 32'(rd_n % v_dep);
      check(s_oa == e && s_os == OB, "R6 output slot", s_oa, e);
      if (take) begin out_next = 1'b1; rd_n++; end
    end
  endtask

  task automatic setup(input bit m, input int cnt, input int dep, input bit u);
    stream_mode = m; frame_count = 16'(cnt); ring_depth = 4'(dep);
    use_user_base = u;
    v_mode = m; v_dep = dep; v_ib = u ? UIB : DIB; v_ob = u ? UOB : DOB;
    wr_n = 0; rd_n = 0; eng_n = 0; fin_n = 0; saw_hs = 1'b0;
    start = 1'b1;
    step(1'b0, 1'b0);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    timer = 0; cyc = 0; v_dep = 2; v_ib = DIB; v_ob = DOB; v_mode = 1'b0;
    wr_n = 0; rd_n = 0; eng_n = 0; fin_n = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!in_valid && !out_valid && !done && !eng_start, "R1 outputs in reset",
          {in_valid, out_valid, done, eng_start}, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check(!in_valid && !out_valid && !done && !eng_start, "R1 outputs after reset",
          {in_valid, out_valid, done, eng_start}, 0);

    // R3: batch with zero count
    setup(1'b0, 0, 2, 1'b0);
    repeat (20) step(1'b0, 1'b0);
    check(eng_n == 0, "R3 no launch on zero batch count", eng_n, 0);
    check(!done, "R3 done stays low", done, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bit early;
      int k;
      early = 1'b0;
      setup(VECS[i].mode, int'(VECS[i].cnt), int'(VECS[i].dep), VECS[i].user);
      k = 0;
      while (k < 3000 && !(done && (!v_mode || rd_n == int'(VECS[i].cnt)))) begin
        step(!VECS[i].gap || (cyc % 2 == 0), (cyc % 4) >= int'(VECS[i].stall));
        if (done && fin_n != int'(VECS[i].cnt)) early = 1'b1;
        k++;
      end
      check(done, "R2 R4 done reached", done, 1);
      check(!early, "R2 R4 done only after last completion", early, 0);
      check(eng_n == int'(VECS[i].exp_runs), "R2 R4 engine run count",
            eng_n, VECS[i].exp_runs);
      if (v_mode) begin
        check(wr_n == int'(VECS[i].cnt), "R4 inputs accepted", wr_n, VECS[i].cnt);
        check(rd_n == int'(VECS[i].cnt), "R4 outputs released", rd_n, VECS[i].cnt);
      end else begin
        check(!saw_hs, "R2 no client handshake in batch", saw_hs, 0);
      end
      repeat (5) step(1'b0, 1'b0);
      check(done, "R11 done held until next start", done, 1);
    end

    // R11: start ignored while running
    setup(1'b1, 0, 2, 1'b0);
    step(1'b1, 1'b1);
    stream_mode = 1'b0; frame_count = 16'd1; start = 1'b1;
    step(1'b1, 1'b1);
    start = 1'b0;
    repeat (3) step(1'b1, 1'b1);
    check(in_valid || out_valid || eng_n != 0, "R11 start ignored while running",
          {in_valid, out_valid}, 1);
    stop = 1'b1; step(1'b0, 1'b1); stop = 1'b0;
    repeat (8) step(1'b0, 1'b1);

    // R8: backpressure, depth 2, outputs never released
    setup(1'b1, 0, 2, 1'b1);
    repeat (40) step(1'b1, 1'b0);
    check(wr_n == 4, "R8 inputs accepted under backpressure", wr_n, 4);
    check(eng_n == 2, "R8 engine runs under backpressure", eng_n, 2);
    check(!in_valid, "R8 input ring full", in_valid, 0);
    check(out_valid, "R8 outputs waiting", out_valid, 1);

    // R10: stop returns to idle
    stop = 1'b1; step(1'b0, 1'b0); stop = 1'b0;
    repeat (6) step(1'b0, 1'b0);
    check(!in_valid && !out_valid && !done, "R10 idle after stop",
          {in_valid, out_valid, done}, 0);

    // R10: restart offers slot 0; stop with a frame in flight
    setup(1'b1, 0, 3, 1'b1);
    while (!in_valid && cyc < 100000) step(1'b0, 1'b1);
    check(in_addr == UIB, "R10 pointers reset on restart", in_addr, UIB);
    while (eng_n == 0 && cyc < 100000) step(1'b1, 1'b1);
    stop = 1'b1; step(1'b0, 1'b0); stop = 1'b0;
    repeat (8) step(1'b0, 1'b0);
    check(fin_n == 1, "R10 frame in flight completes", fin_n, 1);
    check(!in_valid && !out_valid && !done, "R10 idle after drain",
          {in_valid, out_valid, done}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule